// File: doc/BRIEF.md
# Clock-Paced Serial Memory Streamer

This block reads a 128-byte memory one bit at a time and sends it out on a single data line. A separate transmit clock sets the pace, and no command protocol is involved. The transmit clock comes from outside the system clock domain. It is resynchronised internally, and each of its rising edges advances the stream by one bit slot.

After reset or after re-entry, the block first needs a run of synchronising transmit-clock pulses, and it does not drive the line during them. It then sends frames of nine slots. Each frame carries one byte, most significant bit first, followed by one filler slot. After every frame the byte address moves forward, and it wraps from the last location back to zero.

A mode controller gates the block with an enable. The data output and its output enable can drive either an open-drain pad or a tri-state pad.

Top module: `serial_stream_tx`

## Requirements
- R1: While reset is asserted and just after it, `sdo_oe` is 0 and `rd_addr` is 0.
- R2: While enabled, the first 9 transmit-clock rising edges after reset or re-entry leave `sdo_oe` at 0.
- R3: On the 10th transmit-clock rising edge, `sdo_oe` goes to 1 and `sdo` carries bit 7 of the byte at the current address. That address is 0x00 after reset.
- R4: Each byte takes 9 transmit-clock rising edges. Edges 1 to 8 put out bits 7 down to 0 in that order. Edge 9 is a filler slot that drives 1.
- R5: `sdo` and `rd_addr` change only in response to a transmit-clock rising edge. A falling edge changes neither.
- R6: `rd_addr` advances by one on the filler slot of each byte, and it wraps from 127 to 0.
- R7: When `stream_en` falls, `sdo_oe` goes to 0 in the same cycle. While disabled, transmit-clock edges change neither `sdo_oe` nor `rd_addr`.
- R8: After re-enabling, the block again needs 9 synchronising edges. It then restarts at bit 7 of the byte it was sending when it was disabled, because the address is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tclk_async | input | 1 | Transmit clock, asynchronous to `clk` |
| stream_en | input | 1 | Streaming enable from the mode controller |
| rd_addr | output | 7 | Byte address to the memory read port |
| rd_data | input | 8 | Byte returned by the memory for `rd_addr` (combinational read) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data pad |

## Verification
The bench builds the block with its default parameters: 7 address bits, 8 data bits and 9 synchronising pulses. Its memory model returns an arithmetic function of the address. Because of this, a sweep of 130 frames visits every location and crosses the 127-to-0 wrap, and every bit of every byte and every filler slot is compared against that function. The same configuration also covers a disable in the middle of a byte, transmit-clock pulses that arrive while disabled, and a fresh 9-pulse resynchronisation that resumes at the kept address.

// File: rtl/serial_stream_tx.sv
module serial_stream_tx #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_PULSES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tclk_async,
  input  logic              stream_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int FRAME  = DATA_W + 1;
  localparam int SLOT_W = $clog2(FRAME);
  localparam int SYNC_W = $clog2(SYNC_PULSES + 1);

  logic [2:0]        tsync;
  logic              tick;
  logic [SYNC_W-1:0] sync_cnt;
  logic              locked;
  logic [SLOT_W-1:0] slot;
  logic              oe_q, sdo_q;
  logic [DATA_W-1:0] shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) tsync <= '0;
    else        tsync <= {tsync[1:0], tclk_async};
  end

  assign tick    = tsync[1] & ~tsync[2];
  assign shifted = rd_data << slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_cnt <= '0;
      locked   <= 1'b0;
      slot     <= '0;
      oe_q     <= 1'b0;
      sdo_q    <= 1'b1;
      rd_addr  <= '0;
    end else if (!stream_en) begin
      sync_cnt <= '0;
      locked   <= 1'b0;
      slot     <= '0;
      oe_q     <= 1'b0;
    end else if (tick) begin
      if (!locked) begin
        if (sync_cnt == SYNC_W'(SYNC_PULSES - 1)) begin
          locked   <= 1'b1;
          sync_cnt <= '0;
        end else begin
          sync_cnt <= sync_cnt + 1'b1;
        end
      end else begin
        oe_q <= 1'b1;
        if (slot == SLOT_W'(DATA_W)) begin
          sdo_q   <= 1'b1;
          slot    <= '0;
          rd_addr <= rd_addr + 1'b1;
        end else begin
          sdo_q <= shifted[DATA_W-1];
          slot  <= slot + 1'b1;
        end
      end
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q & stream_en;
endmodule

// File: rtl/serial_stream_tx_chk.sv
module serial_stream_tx_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stream_en,
  input logic              tick,
  input logic              locked,
  input logic [SLOT_W-1:0] slot,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              sdo,
  input logic              sdo_oe
);
  a_r2_quiet_until_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !sdo_oe);

  a_r3_first_bit_msb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> sdo == $past(rd_data[DATA_W-1]));

  a_r4_filler_high: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_en && tick && locked && slot == SLOT_W'(DATA_W)) |=> sdo);

  a_r5_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(sdo) && $stable(rd_addr)));

  a_r6_addr_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_addr) |-> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));

  a_r8_relock_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stream_en) |=> !locked);
endmodule

bind serial_stream_tx serial_stream_tx_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .tick(tick),
  .locked(locked), .slot(slot), .rd_addr(rd_addr), .rd_data(rd_data),
  .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/tb_serial_stream_tx.sv
`timescale 1ns/1ps
module tb_serial_stream_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tclk_async = 1'b0;
  logic       stream_en = 1'b0;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       sdo, sdo_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_of(input logic [6:0] a);
    return 8'((a * 37 + 5) ^ (a >> 3));
  endfunction

  assign rd_data = mem_of(rd_addr);

  serial_stream_tx dut (
    .clk(clk), .rst_n(rst_n), .tclk_async(tclk_async), .stream_en(stream_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(output logic o_sdo, output logic o_oe, output logic [6:0] o_addr);
    tclk_async = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    o_sdo = sdo; o_oe = sdo_oe; o_addr = rd_addr;
    tclk_async = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R5 falling edge leaves sdo", sdo, o_sdo);
    chk("R5 falling edge leaves addr", rd_addr, o_addr);
  endtask

  task automatic sync_run(input string req);
    logic s, o; logic [6:0] a;
    for (int i = 0; i < 9; i++) begin
      pulse(s, o, a);
      chk(req, o, 1'b0);
    end
  endtask

  task automatic stream_bytes(input int nbytes, inout logic [6:0] ea, inout bit first);
    logic s, o; logic [6:0] a;
    for (int b = 0; b < nbytes; b++) begin
      for (int k = 0; k < 9; k++) begin
        pulse(s, o, a);
        if (first) begin
          chk("R3 oe on tenth edge", o, 1'b1);
          chk("R3 msb of start byte", s, mem_of(ea)[7]);
          first = 0;
        end else if (k < 8) begin
          chk("R4 data bit", s, mem_of(ea)[7-k]);
          chk("R4 oe held", o, 1'b1);
        end else begin
          chk("R4 filler slot drives 1", s, 1'b1);
        end
        if (k == 8) begin
          ea = ea + 7'd1;
          chk(ea == 7'd0 ? "R6 wrap 127 to 0" : "R6 address advance", a, ea);
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [6:0] ea;
    bit first;
    logic s, o; logic [6:0] a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 oe in reset", sdo_oe, 1'b0);
    chk("R1 addr in reset", rd_addr, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", sdo_oe, 1'b0);
    stream_en = 1'b1;
    sync_run("R2 quiet during sync");
    ea = 7'd0; first = 1;
    stream_bytes(130, ea, first);
    // Disable three bits into the byte at ea.
    for (int k = 0; k < 3; k++) begin
      pulse(s, o, a);
      chk("R4 data bit", s, mem_of(ea)[7-k]);
    end
    stream_en = 1'b0;
    #1;
    chk("R7 oe drops at once", sdo_oe, 1'b0);
    for (int i = 0; i < 20; i++) begin
      pulse(s, o, a);
      chk("R7 oe stays low when disabled", o, 1'b0);
      chk("R7 addr held when disabled", a, ea);
    end
    stream_en = 1'b1;
    sync_run("R8 resync quiet");
    first = 1;
    stream_bytes(3, ea, first);
    chk("R8 resumed address advanced", rd_addr, ea);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule